// File: doc/BRIEF.md
# Burst-of-Two Late-Write SRAM Core

This block is a synthesizable memory that behaves like a double-data-rate static RAM whose bursts are always two words long. A command is a load strobe, a read/write select and a pair address. Write data and byte enables follow their write command by one command cycle, one word per half-cycle. Read data comes back two and a half command cycles after the read command, also as two consecutive half-cycle words, with an output enable that marks them. Separate data-in and data-out ports plus the enable stand in for a shared bidirectional bus.

The block runs on an internal clock at twice the command rate. A phase flag, exported as `cmd_slot`, marks the clock periods whose closing edge is a command edge. The system side drives commands in those periods and write beats in the two periods after a write command. A read issued right after a write to the same pair returns the merged new data. A write issued right after a read does not disturb the data that read returns.

Top module: `burst2_sram`

## Requirements
- R1: A command address `a` names the word pair `2a` (first beat) and `2a+1` (second beat), for both reads and writes.
- R2: `cmd_slot` is high in the first clock period after reset and toggles every period. `cmd_ld`, `cmd_wr` and `cmd_addr` are sampled only at the edge that closes a period with `cmd_slot` high, and are ignored at every other edge.
- R3: For a write command sampled at edge n, the first data beat is taken at edge n+2 and the second at edge n+3. Data presented at any other edge is ignored.
- R4: `wr_be` is taken with each beat and may differ between the two beats. Bit i, when 1, writes data bits 9i to 9i+8 (bit 0: bits 0–8, bit 3: bits 27–35). A lane whose bit is 0 keeps its stored value.
- R5: For a read command sampled at edge n, `rd_oe` goes high after edge n+5 with the first word on `rd_data`, and stays high after edge n+6 with the second word. Each read accounts for exactly those two periods of `rd_oe`.
- R6: A read returns the effect of every write commanded before it, including the write in the immediately preceding command slot whose beats are still arriving. No write commanded after the read changes what it returns.
- R7: With `cmd_ld` low at a command edge, nothing is written, no read data is produced and the stored contents are unchanged.
- R8: Reads and writes may be issued in every command slot, in any mix, with no stall or lost command.
- R9: After reset, `rd_oe` is low and `rd_data` is zero.
- R10: Whenever `rd_oe` is low, `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_ld | input | 1 | Load strobe; 1 issues a command in this slot |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW (4) | Pair address |
| wr_data | input | DATA_W (36) | Write beat data |
| wr_be | input | NB (4) | Per-lane write enables for the current beat |
| rd_data | output | DATA_W (36) | Read beat data |
| rd_oe | output | 1 | High while `rd_data` carries a read beat |
| cmd_slot | output | 1 | High in periods whose closing edge samples a command |

## Verification
The hardest case to reach is a read that lands on the pair whose write is still in flight. The read is sampled at the same edge as that write's first beat, and the second beat arrives one edge later, so both forwarding paths act while the array still holds stale data. The bench reaches it by issuing a write and then a read of the same pair in the next slot, once with full enables and once with enables that differ per beat. The reverse case is also directed: a read, then a write to the same pair, then a second read, where only the second read may see the new data. A long random mix of back-to-back commands, with junk driven on every non-command edge, is compared against a byte-masked reference memory.

// File: rtl/b2s_pkg.sv
package b2s_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } b2s_cmd_e;

    function automatic b2s_cmd_e b2s_decode(input logic ld, input logic wr);
        if (!ld)
            return CMD_IDLE;
        return wr ? CMD_WRITE : CMD_READ;
    endfunction

endpackage

// File: rtl/b2s_lane_merge.sv
module b2s_lane_merge #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned NB    = DATA_W / LANE_W
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [NB-1:0]     lane_en,
    output logic [DATA_W-1:0] merged
);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = lane_en[i] ? new_word[i*LANE_W +: LANE_W]
                                                       : old_word[i*LANE_W +: LANE_W];
    end

    if (NB * LANE_W < DATA_W) begin : g_tail
        assign merged[DATA_W-1:NB*LANE_W] = old_word[DATA_W-1:NB*LANE_W];
    end

endmodule

// File: rtl/b2s_store.sv
module b2s_store #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned AW     = 4,
    localparam int unsigned NB    = DATA_W / LANE_W,
    localparam int unsigned WORDS = 2 ** (AW + 1)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW:0]       waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NB-1:0]     wbe,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rword0,
    output logic [DATA_W-1:0] rword1
);

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] wmerged;

    b2s_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_wmerge (
        .old_word (mem[waddr]),
        .new_word (wdata),
        .lane_en  (wbe),
        .merged   (wmerged)
    );

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wmerged;
    end

    assign rword0 = mem[{raddr, 1'b0}];
    assign rword1 = mem[{raddr, 1'b1}];

endmodule

// File: rtl/b2s_read_pipe.sv
module b2s_read_pipe #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned AW     = 4,
    localparam int unsigned NB    = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              rd_cap,
    input  logic [AW-1:0]     rd_addr,
    input  logic [DATA_W-1:0] arr_w0,
    input  logic [DATA_W-1:0] arr_w1,
    input  logic              wcmd_vld,
    input  logic [AW-1:0]     wcmd_addr,
    input  logic              wdat_vld,
    input  logic [AW-1:0]     wdat_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);

    typedef struct packed {
        logic              a_vld;
        logic [AW-1:0]     a_addr;
        logic [DATA_W-1:0] a_w0;
        logic [DATA_W-1:0] a_w1;
        logic              b_vld;
        logic [DATA_W-1:0] b_w0;
        logic [DATA_W-1:0] b_w1;
        logic              c_vld;
        logic [DATA_W-1:0] c_w0;
        logic [DATA_W-1:0] c_w1;
        logic              oe;
        logic [DATA_W-1:0] dout;
    } rp_t;

    rp_t rp_d, rp_q;

    logic              fwd0_hit, fwd1_hit;
    logic [DATA_W-1:0] fwd_w0, fwd_w1;

    // first beat of the preceding write arrives at the same edge as the read capture
    assign fwd0_hit = wcmd_vld && (wcmd_addr == rd_addr);
    // its second beat arrives one half-cycle later, while the read sits in stage a
    assign fwd1_hit = rp_q.a_vld && wdat_vld && (wdat_addr == rp_q.a_addr);

    b2s_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_fwd0 (
        .old_word (arr_w0),
        .new_word (wr_data),
        .lane_en  (wr_be),
        .merged   (fwd_w0)
    );

    b2s_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_fwd1 (
        .old_word (rp_q.a_w1),
        .new_word (wr_data),
        .lane_en  (wr_be),
        .merged   (fwd_w1)
    );

    always_comb begin
        rp_d = rp_q;
        if (slot) begin
            rp_d.c_vld  = rp_q.b_vld;
            rp_d.c_w0   = rp_q.b_w0;
            rp_d.c_w1   = rp_q.b_w1;
            rp_d.b_vld  = rp_q.a_vld;
            rp_d.b_w0   = rp_q.a_w0;
            rp_d.b_w1   = rp_q.a_w1;
            rp_d.a_vld  = rd_cap;
            rp_d.a_addr = rd_addr;
            rp_d.a_w0   = fwd0_hit ? fwd_w0 : arr_w0;
            rp_d.a_w1   = arr_w1;
        end else if (fwd1_hit) begin
            rp_d.a_w1   = fwd_w1;
        end
        rp_d.oe   = rp_q.c_vld;
        rp_d.dout = rp_q.c_vld ? (slot ? rp_q.c_w1 : rp_q.c_w0) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rp_q <= '0;
        else
            rp_q <= rp_d;
    end

    assign rd_data = rp_q.dout;
    assign rd_oe   = rp_q.oe;

    assert_oe_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_oe) |=> rd_oe)
        else $error("read enable did not span two beats");

    assert_oe_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_oe) |-> slot)
        else $error("first read beat on the wrong half-cycle");

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe |-> (rd_data == '0))
        else $error("read data not zero while disabled");

endmodule

// File: rtl/burst2_sram.sv
module burst2_sram #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned LANE_W = 9,
    parameter int unsigned PAIRS  = 16,
    localparam int unsigned AW    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int unsigned NB    = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_ld,
    input  logic              cmd_wr,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [NB-1:0]     wr_be,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe,
    output logic              cmd_slot
);

    import b2s_pkg::*;

    typedef struct packed {
        logic          phase;
        logic          wcmd_vld;
        logic [AW-1:0] wcmd_addr;
        logic          wdat_vld;
        logic [AW-1:0] wdat_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    b2s_cmd_e          cmd;
    logic              slot;
    logic              st_we;
    logic [AW:0]       st_waddr;
    logic [DATA_W-1:0] arr_w0, arr_w1;
    logic              rd_cap;

    assign slot = ~ctl_q.phase;
    assign cmd  = b2s_decode(cmd_ld, cmd_wr);

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.phase = ~ctl_q.phase;
        if (slot) begin
            ctl_d.wdat_vld  = ctl_q.wcmd_vld;
            ctl_d.wdat_addr = ctl_q.wcmd_addr;
            ctl_d.wcmd_vld  = (cmd == CMD_WRITE);
            if (cmd == CMD_WRITE)
                ctl_d.wcmd_addr = cmd_addr;
        end else begin
            ctl_d.wdat_vld  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    // beat 0 lands on the command edge after the write, beat 1 half a cycle later
    assign st_we    = slot ? ctl_q.wcmd_vld : ctl_q.wdat_vld;
    assign st_waddr = slot ? {ctl_q.wcmd_addr, 1'b0} : {ctl_q.wdat_addr, 1'b1};
    assign rd_cap   = slot && (cmd == CMD_READ);

    b2s_store #(.DATA_W(DATA_W), .LANE_W(LANE_W), .AW(AW)) i_store (
        .clk    (clk),
        .we     (st_we),
        .waddr  (st_waddr),
        .wdata  (wr_data),
        .wbe    (wr_be),
        .raddr  (cmd_addr),
        .rword0 (arr_w0),
        .rword1 (arr_w1)
    );

    b2s_read_pipe #(.DATA_W(DATA_W), .LANE_W(LANE_W), .AW(AW)) i_rpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .rd_cap    (rd_cap),
        .rd_addr   (cmd_addr),
        .arr_w0    (arr_w0),
        .arr_w1    (arr_w1),
        .wcmd_vld  (ctl_q.wcmd_vld),
        .wcmd_addr (ctl_q.wcmd_addr),
        .wdat_vld  (ctl_q.wdat_vld),
        .wdat_addr (ctl_q.wdat_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .rd_data   (rd_data),
        .rd_oe     (rd_oe)
    );

    assign cmd_slot = slot;

    logic rd_issue, wr_issue;
    assign rd_issue = rst_n && slot && cmd_ld && !cmd_wr;
    assign wr_issue = rst_n && slot && cmd_ld && cmd_wr;

    assert_slot_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_slot |=> !cmd_slot)
        else $error("command slot did not toggle low");

    assert_slot_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_slot |=> cmd_slot)
        else $error("command slot did not toggle high");

    assert_beat0_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && slot) |-> $past(wr_issue, 2))
        else $error("first beat written without a write two edges earlier");

    assert_beat1_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !slot) |-> $past(wr_issue, 3))
        else $error("second beat written without a write three edges earlier");

    assert_first_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_issue, 6) |-> rd_oe)
        else $error("first read beat missing");

    assert_second_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_issue, 7) |-> rd_oe)
        else $error("second read beat missing");

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> ($past(rd_issue, 6) || $past(rd_issue, 7)))
        else $error("read enable without a read command");

endmodule

// File: tb/test_burst2_sram.sv
module test_burst2_sram;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 36;
    localparam int LW    = 9;
    localparam int PAIRS = 16;
    localparam int AW    = 4;
    localparam int NB    = DW / LW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_ld, cmd_wr;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] wr_data;
    logic [NB-1:0] wr_be;
    logic [DW-1:0] rd_data;
    logic          rd_oe;
    logic          cmd_slot;

    burst2_sram #(.DATA_W(DW), .LANE_W(LW), .PAIRS(PAIRS)) i_burst2_sram (
        .clk(clk), .rst_n(rst_n), .cmd_ld(cmd_ld), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_oe(rd_oe), .cmd_slot(cmd_slot)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;

    logic [DW-1:0] ref_mem [2*PAIRS];

    logic          pv_v  [3];
    logic [DW-1:0] pv_e0 [3];
    logic [DW-1:0] pv_e1 [3];
    string         pv_tag[3];

    logic          pw_v;
    logic [AW-1:0] pw_addr;
    logic [DW-1:0] pw_d0, pw_d1;
    logic [NB-1:0] pw_b0, pw_b1;

    function automatic logic [DW-1:0] rnd_word();
        logic [DW-1:0] w;
        for (int i = 0; i < DW; i++) w[i] = 1'($urandom);
        return w;
    endfunction

    function automatic logic [DW-1:0] lane_mix(logic [DW-1:0] old_w, logic [DW-1:0] upd,
                                               logic [NB-1:0] be);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < NB; i++)
            if (be[i]) r[i*LW +: LW] = upd[i*LW +: LW];
        return r;
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input bit beat);
        if (pv_v[2]) begin
            check(pv_tag[2], DW'(rd_oe), DW'(1));
            check(pv_tag[2], rd_data, beat ? pv_e1[2] : pv_e0[2]);
        end else begin
            check("R7", DW'(rd_oe), DW'(0));
            check("R10", rd_data, '0);
        end
    endtask

    // one command cycle: two clock periods, entered and left just after a negedge
    task automatic cmd_cycle(input logic ld, input logic wr, input logic [AW-1:0] addr,
                             input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                             input logic [NB-1:0] b0, input logic [NB-1:0] b1,
                             input string req);
        check("R2", DW'(cmd_slot), DW'(1));
        check_out(1'b0);
        cmd_ld   = ld;
        cmd_wr   = wr;
        cmd_addr = addr;
        wr_data  = pw_v ? pw_d0 : rnd_word();
        wr_be    = pw_v ? pw_b0 : NB'($urandom);
        @(negedge clk);
        check_out(1'b1);
        // junk command on the off half-cycle must be ignored (R2)
        cmd_ld   = 1'b1;
        cmd_wr   = 1'($urandom);
        cmd_addr = AW'($urandom);
        wr_data  = pw_v ? pw_d1 : rnd_word();
        wr_be    = pw_v ? pw_b1 : NB'($urandom);
        @(negedge clk);
        if (pw_v) begin
            ref_mem[{pw_addr, 1'b0}] = lane_mix(ref_mem[{pw_addr, 1'b0}], pw_d0, pw_b0);
            ref_mem[{pw_addr, 1'b1}] = lane_mix(ref_mem[{pw_addr, 1'b1}], pw_d1, pw_b1);
        end
        for (int s = 2; s > 0; s--) begin
            pv_v[s] = pv_v[s-1]; pv_e0[s] = pv_e0[s-1];
            pv_e1[s] = pv_e1[s-1]; pv_tag[s] = pv_tag[s-1];
        end
        pv_v[0]   = ld && !wr;
        pv_e0[0]  = ref_mem[{addr, 1'b0}];
        pv_e1[0]  = ref_mem[{addr, 1'b1}];
        pv_tag[0] = req;
        pw_v    = ld && wr;
        pw_addr = addr;
        pw_d0 = d0; pw_d1 = d1; pw_b0 = b0; pw_b1 = b1;
    endtask

    task automatic do_wr(input logic [AW-1:0] a, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                         input logic [NB-1:0] b0, input logic [NB-1:0] b1, input string req);
        cmd_cycle(1'b1, 1'b1, a, d0, d1, b0, b1, req);
    endtask

    task automatic do_rd(input logic [AW-1:0] a, input string req);
        cmd_cycle(1'b1, 1'b0, a, rnd_word(), rnd_word(), '0, '0, req);
    endtask

    task automatic do_nop(input int n);
        for (int i = 0; i < n; i++)
            cmd_cycle(1'b0, 1'($urandom), AW'($urandom), rnd_word(), rnd_word(),
                      NB'($urandom), NB'($urandom), "R7");
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cmd_ld = 1'b0; cmd_wr = 1'b0; cmd_addr = '0;
        wr_data = '0; wr_be = '0;
        pw_v = 1'b0;
        for (int s = 0; s < 3; s++) begin
            pv_v[s] = 1'b0; pv_e0[s] = '0; pv_e1[s] = '0; pv_tag[s] = "R9";
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9", DW'(rd_oe), DW'(0));
        check("R9", rd_data, '0);
        check("R2", DW'(cmd_slot), DW'(1));
    endtask

    task automatic t_fill();
        for (int a = 0; a < PAIRS; a++)
            do_wr(AW'(a), rnd_word(), rnd_word(), '1, '1, "R3");
        for (int a = 0; a < PAIRS; a++)
            do_rd(AW'(a), "R1");
        do_nop(3);
    endtask

    task automatic t_raw();
        do_wr(AW'(3), rnd_word(), rnd_word(), '1, '1, "R6");
        do_rd(AW'(3), "R6");
        do_wr(AW'(5), rnd_word(), rnd_word(), NB'(4'b0011), NB'(4'b1100), "R6");
        do_rd(AW'(5), "R6");
        do_nop(3);
    endtask

    task automatic t_partial();
        do_wr(AW'(7), rnd_word(), rnd_word(), NB'(4'b0101), NB'(4'b1010), "R4");
        do_nop(1);
        do_rd(AW'(7), "R4");
        do_wr(AW'(8), rnd_word(), rnd_word(), '0, NB'(4'b1000), "R4");
        do_nop(1);
        do_rd(AW'(8), "R4");
        do_nop(3);
    endtask

    task automatic t_later_write();
        do_rd(AW'(9), "R6");
        do_wr(AW'(9), rnd_word(), rnd_word(), '1, '1, "R6");
        do_rd(AW'(9), "R6");
        do_rd(AW'(9), "R6");
        do_nop(3);
    endtask

    task automatic t_idle();
        do_nop(6);
        do_rd(AW'(2), "R7");
        do_rd(AW'(9), "R7");
        do_nop(3);
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 8; i++) begin
            do_wr(AW'(i + 1), rnd_word(), rnd_word(), NB'($urandom), NB'($urandom), "R8");
            do_rd(AW'(i), "R8");
        end
        do_nop(3);
    endtask

    task automatic t_random();
        for (int i = 0; i < 300; i++)
            cmd_cycle(1'($urandom % 4 != 0), 1'($urandom), AW'($urandom % 4),
                      rnd_word(), rnd_word(), NB'($urandom), NB'($urandom), "R8");
        do_nop(3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_raw();
        t_partial();
        t_later_write();
        t_idle();
        t_alternate();
        t_random();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule